// File: doc/BRIEF.md
# Dual-Channel Output Agreement Monitor

This block sits in one of two redundant channels that each compute the same safety function. It compares its own output word against the partner channel's word. It also watches a toggling keep-alive bit that the partner sends, and it drives its own keep-alive toggle back. The partner's word reaches this block already aligned to the local clock. The keep-alive and the operator acknowledge are asynchronous, so the block synchronizes both itself.

The block has no vote, because two channels cannot tell which one is wrong. It has two kinds of fault. One is a mismatch that lasts for several compare cycles. The other is a keep-alive that stops changing. On either fault the block does four things in order:
- it turns the safe outputs off;
- it raises a reset request for a fixed number of cycles;
- it waits for a settle period;
- it then either retries or locks out.

Retrying is limited by a trip budget over a sliding window, which stops a slow on/off oscillation. The latched policy always waits for an operator acknowledge.

The word inputs are valid-only streams and have no back-pressure. The block always accepts a word. A compare takes place only in a cycle where both valid inputs are high. Cycles where only one side is valid are ignored.

Top module: `agree_monitor`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state is INIT (`state_o` = 0) with `safe_en`, `reset_req` and `safe_word` all zero. After exactly SETTLE clock edges the state becomes RUN (`state_o` = 1).
- R2: `safe_en` is high only in RUN. In RUN, `safe_word` equals `local_word`. In every other state `safe_word` is zero.
- R3: A compare happens in a cycle where `local_valid` and `peer_valid` are both high. Each differing compare adds one to the streak, and a matching compare clears it. Cycles without a compare leave the streak unchanged. The MM_RUN-th consecutive differing compare (3 by default) moves RUN to TRIPPED (`state_o` = 2) at that clock edge.
- R4: `peer_hb` passes through a two-flop synchronizer. If no transition of it is seen for HB_TIMEOUT cycles while in RUN, the block trips.
- R5: TRIPPED lasts one cycle and is followed by RESETTING (`state_o` = 3) for RST_HOLD+SETTLE cycles. `reset_req` is high for exactly the first RST_HOLD cycles of RESETTING and is never high at any other time.
- R6: With `mode_latch` = 0, RESETTING returns to RUN unless the trip budget is used up.
- R7: If a trip is the TRIP_LIMIT-th one counted within WINDOW cycles of the trip that opened the window, RESETTING ends in LOCKOUT (`state_o` = 4). When a window expires, the count returns to zero.
- R8: With `mode_latch` = 1, every RESETTING ends in LOCKOUT.
- R9: LOCKOUT is left only on a synchronized rising edge of `ack_btn`, which moves the state to INIT and clears the trip budget. Holding `ack_btn` high has no effect, and `ack_btn` has no effect outside LOCKOUT.
- R10: `hb_out` toggles once every HB_HALF clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_latch | input | 1 | Recovery policy: 1 = latched (always lock out), 0 = retry within the budget |
| local_valid | input | 1 | Local word valid |
| local_word | input | WIDTH | Local channel output word |
| peer_valid | input | 1 | Partner word valid |
| peer_word | input | WIDTH | Partner channel output word |
| peer_hb | input | 1 | Partner keep-alive toggle (asynchronous) |
| ack_btn | input | 1 | Operator acknowledge (asynchronous) |
| hb_out | output | 1 | Own keep-alive toggle sent to the partner |
| safe_en | output | 1 | Safe outputs enabled |
| safe_word | output | WIDTH | Gated local word |
| reset_req | output | 1 | Channel reset request |
| state_o | output | 3 | State code: 0 INIT, 1 RUN, 2 TRIPPED, 3 RESETTING, 4 LOCKOUT |

## Verification
The bound assertions check on every cycle the shape of the state sequence:
- TRIPPED is entered only from RUN and always leads into RESETTING.
- RUN is entered only from INIT or RESETTING.
- LOCKOUT holds until an acknowledge edge arrives.
- The latched policy never retries.
- `reset_req` pulses are exactly RST_HOLD cycles long.

Some behaviour only the bench scenarios can show: the streak counting across idle and one-sided cycles, the heartbeat timeout distance, the trip budget being exhausted and then reopened after the window expires, and a held button failing to restart the block. The bench also sweeps every pair of 4-bit words as isolated compares to show that one disagreement never trips the block.

// File: rtl/agree_pkg.sv
package agree_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_RUN   = 3'd1,
    ST_TRIP  = 3'd2,
    ST_RESET = 3'd3,
    ST_LOCK  = 3'd4
  } agree_state_e;
endpackage

// File: rtl/agree_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
module agree_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/agree_mismatch_filter.sv
// Counts consecutive differing compares; flags the one that completes the run.
module agree_mismatch_filter #(
  parameter int WIDTH   = 8,
  parameter int RUN_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             a_valid,
  input  logic [WIDTH-1:0] a_word,
  input  logic             b_valid,
  input  logic [WIDTH-1:0] b_word,
  output logic             trip
);
  localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] streak;
  logic          compare, differ;

  assign compare = a_valid && b_valid;
  assign differ  = (a_word != b_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   streak <= '0;
    else if (!enable)             streak <= '0;
    else if (compare && !differ)  streak <= '0;
    else if (compare && streak != LAST) streak <= streak + 1'b1;
  end

  assign trip = enable && compare && differ && (streak == LAST);
endmodule

// File: rtl/agree_hb_watchdog.sv
// Watches the partner keep-alive and generates the local one.
module agree_hb_watchdog #(
  parameter int TIMEOUT = 1024,
  parameter int HALF    = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic peer_hb,
  output logic hb_out,
  output logic fault
);
  localparam int TW = $clog2(TIMEOUT);
  localparam int HW = $clog2(HALF);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);
  localparam logic [HW-1:0] H_LAST = HW'(HALF - 1);

  logic          hb_s, hb_prev, seen;
  logic [TW-1:0] idle_cnt;
  logic [HW-1:0] tx_cnt;

  agree_sync #(.STAGES(2)) u_hb_sync (
    .clk(clk), .rst_n(rst_n), .d(peer_hb), .q(hb_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hb_prev <= 1'b0;
    else        hb_prev <= hb_s;
  end

  assign seen = hb_s ^ hb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!enable || seen)   idle_cnt <= '0;
    else if (idle_cnt != T_LAST) idle_cnt <= idle_cnt + 1'b1;
  end

  assign fault = enable && !seen && (idle_cnt == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      hb_out <= 1'b0;
    end else if (tx_cnt == H_LAST) begin
      tx_cnt <= '0;
      hb_out <= ~hb_out;
    end else begin
      tx_cnt <= tx_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/agree_trip_budget.sv
// Counts trips inside a window opened by the first trip; flags exhaustion.
module agree_trip_budget #(
  parameter int LIMIT  = 4,
  parameter int WINDOW = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic trip,
  output logic exhausted
);
  localparam int TW = $clog2(WINDOW);
  localparam int NW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] W_LAST = TW'(WINDOW - 1);
  localparam logic [NW-1:0] N_MAX  = NW'(LIMIT);

  logic          active;
  logic [TW-1:0] timer;
  logic [NW-1:0] count;
  logic          expire;

  assign expire = active && (timer == W_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; timer <= '0; count <= '0;
    end else if (clear) begin
      active <= 1'b0; timer <= '0; count <= '0;
    end else if (trip) begin
      if (!active || expire) begin
        active <= 1'b1; timer <= '0; count <= NW'(1);
      end else begin
        timer <= timer + 1'b1;
        if (count != N_MAX) count <= count + 1'b1;
      end
    end else if (expire) begin
      active <= 1'b0; timer <= '0; count <= '0;
    end else if (active) begin
      timer <= timer + 1'b1;
    end
  end

  assign exhausted = (count >= N_MAX);
endmodule

// File: rtl/agree_monitor.sv
module agree_monitor
  import agree_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int MM_RUN     = 3,
  parameter int HB_TIMEOUT = 1024,
  parameter int HB_HALF    = 256,
  parameter int RST_HOLD   = 16,
  parameter int SETTLE     = 64,
  parameter int TRIP_LIMIT = 4,
  parameter int WINDOW     = 1 << 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_latch,
  input  logic             local_valid,
  input  logic [WIDTH-1:0] local_word,
  input  logic             peer_valid,
  input  logic [WIDTH-1:0] peer_word,
  input  logic             peer_hb,
  input  logic             ack_btn,
  output logic             hb_out,
  output logic             safe_en,
  output logic [WIDTH-1:0] safe_word,
  output logic             reset_req,
  output logic [2:0]       state_o
);
  localparam int PW = $clog2(RST_HOLD + SETTLE);
  localparam logic [PW-1:0] INIT_LAST  = PW'(SETTLE - 1);
  localparam logic [PW-1:0] RESET_LAST = PW'(RST_HOLD + SETTLE - 1);
  localparam logic [PW-1:0] HOLD_END   = PW'(RST_HOLD);

  agree_state_e  state;
  logic [PW-1:0] phase;
  logic          run, mm_trip, hb_fault, trip_now;
  logic          ack_s, ack_prev, ack_rise;
  logic          exhausted, budget_clear;

  assign run = (state == ST_RUN);

  agree_mismatch_filter #(.WIDTH(WIDTH), .RUN_LEN(MM_RUN)) u_filter (
    .clk(clk), .rst_n(rst_n), .enable(run),
    .a_valid(local_valid), .a_word(local_word),
    .b_valid(peer_valid),  .b_word(peer_word),
    .trip(mm_trip)
  );

  agree_hb_watchdog #(.TIMEOUT(HB_TIMEOUT), .HALF(HB_HALF)) u_hb (
    .clk(clk), .rst_n(rst_n), .enable(run), .peer_hb(peer_hb),
    .hb_out(hb_out), .fault(hb_fault)
  );

  agree_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_btn), .q(ack_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b0;
    else        ack_prev <= ack_s;
  end

  assign ack_rise     = ack_s && !ack_prev;
  assign trip_now     = run && (mm_trip || hb_fault);
  assign budget_clear = (state == ST_LOCK) && ack_rise;

  agree_trip_budget #(.LIMIT(TRIP_LIMIT), .WINDOW(WINDOW)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(budget_clear), .trip(trip_now),
    .exhausted(exhausted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INIT;
      phase <= '0;
    end else begin
      unique case (state)
        ST_INIT: begin
          if (phase == INIT_LAST) begin state <= ST_RUN; phase <= '0; end
          else phase <= phase + 1'b1;
        end
        ST_RUN: if (trip_now) state <= ST_TRIP;
        ST_TRIP: begin state <= ST_RESET; phase <= '0; end
        ST_RESET: begin
          if (phase == RESET_LAST) begin
            state <= (mode_latch || exhausted) ? ST_LOCK : ST_RUN;
            phase <= '0;
          end else phase <= phase + 1'b1;
        end
        ST_LOCK: if (ack_rise) begin state <= ST_INIT; phase <= '0; end
        default: begin state <= ST_INIT; phase <= '0; end
      endcase
    end
  end

  assign safe_en   = run;
  assign safe_word = run ? local_word : '0;
  assign reset_req = (state == ST_RESET) && (phase < HOLD_END);
  assign state_o   = state;
endmodule

// File: rtl/agree_monitor_chk.sv
module agree_monitor_chk #(
  parameter int RST_HOLD = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       reset_req,
  input logic       safe_en,
  input logic       mode_latch,
  input logic       ack_rise
);
  localparam int RW = $clog2(RST_HOLD + 2);
  logic [RW-1:0] req_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_run <= '0;
    else if (reset_req) req_run <= req_run + 1'b1;
    else                req_run <= '0;
  end

  // R3 / R4: TRIPPED is entered only from RUN
  assert_trip_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2) |-> ($past(state) == 3'd1));

  assert_trip_to_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2) |=> (state == 3'd3));

  assert_req_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (req_run < RW'(RST_HOLD)));

  assert_req_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> ($past(req_run) == RW'(RST_HOLD - 1)));

  assert_req_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (state == 3'd3));

  assert_run_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && $past(state) != 3'd1) |->
      ($past(state) == 3'd0 || $past(state) == 3'd3));

  assert_latch_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_latch && $past(mode_latch) && $past(state) == 3'd3 && state != 3'd3)
      |-> (state == 3'd4));

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !ack_rise) |=> (state == 3'd4));

  assert_lock_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && ack_rise) |=> (state == 3'd0));

  assert_enable_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safe_en) |-> (state == 3'd2));
endmodule

bind agree_monitor agree_monitor_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_o), .reset_req(reset_req),
  .safe_en(safe_en), .mode_latch(mode_latch), .ack_rise(ack_rise)
);

// File: tb/agree_monitor_bench.sv
`timescale 1ns/1ps
module agree_monitor_bench;
  localparam int W = 4, MMR = 3, HBT = 40, HBH = 5, HOLD = 4, SET = 8;
  localparam int LIM = 3, WIN = 120;

  logic clk = 1'b0, rst_n = 1'b0, mode_latch = 1'b0;
  logic local_valid = 1'b0, peer_valid = 1'b0, peer_hb = 1'b0, ack_btn = 1'b0;
  logic [W-1:0] local_word = '0, peer_word = '0;
  logic hb_out, safe_en, reset_req;
  logic [W-1:0] safe_word;
  logic [2:0] state_o;
  logic hb_on = 1'b1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  agree_monitor #(.WIDTH(W), .MM_RUN(MMR), .HB_TIMEOUT(HBT), .HB_HALF(HBH),
    .RST_HOLD(HOLD), .SETTLE(SET), .TRIP_LIMIT(LIM), .WINDOW(WIN)) u_agree_monitor (
    .clk(clk), .rst_n(rst_n), .mode_latch(mode_latch),
    .local_valid(local_valid), .local_word(local_word),
    .peer_valid(peer_valid), .peer_word(peer_word),
    .peer_hb(peer_hb), .ack_btn(ack_btn), .hb_out(hb_out),
    .safe_en(safe_en), .safe_word(safe_word), .reset_req(reset_req),
    .state_o(state_o));

  initial begin : hb_gen
    int n = 0;
    forever begin
      @(posedge clk); #2;
      n++;
      if (hb_on && n % 8 == 0) peer_hb = ~peer_hb;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // drive one compare: same=1 matching words, else differing
  task automatic cmp(input bit lv, input bit pv, input bit same);
    local_valid = lv; peer_valid = pv;
    local_word = 4'h5; peer_word = same ? 4'h5 : 4'hA;
    tick();
    local_valid = 0; peer_valid = 0;
  endtask

  // force a mismatch trip then follow RESETTING; returns final state
  task automatic trip_cycle(input string req, output int fin);
    int req_n = 0, res_n = 0;
    cmp(1, 1, 0); cmp(1, 1, 0);
    chk(state_o == 3'd1, "R3", state_o, 1);
    cmp(1, 1, 0);
    chk(state_o == 3'd2 && !safe_en && reset_req == 0, "R3", state_o, 2);
    tick();
    while (state_o == 3'd3 && res_n < 100) begin
      res_n++; if (reset_req) req_n++;
      tick();
    end
    chk(res_n == HOLD + SET, "R5", res_n, HOLD + SET);
    chk(req_n == HOLD, "R5", req_n, HOLD);
    fin = state_o;
  endtask

  task automatic ack_exit(input string req);
    int n = 0;
    ack_btn = 1;
    while (state_o != 3'd0 && n < 10) begin tick(); n++; end
    chk(state_o == 3'd0, req, state_o, 0);
    n = 0;
    while (state_o != 3'd1 && n < 20) begin tick(); n++; end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin : main
    int n, fin, tg;
    logic last;
    repeat (5) tick();
    chk(state_o == 3'd0 && !safe_en && !reset_req && safe_word == 0, "R1", state_o, 0);
    rst_n = 1;
    n = 0;
    while (state_o != 3'd1 && n < 50) begin
      chk(safe_word == 0 && !safe_en, "R2", safe_word, 0);
      tick(); n++;
    end
    chk(n == SET, "R1", n, SET);

    // R2/R3 sweep: every word pair as one isolated compare
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        local_valid = 1; peer_valid = 1; local_word = a[W-1:0]; peer_word = b[W-1:0];
        #1;
        chk(safe_en && safe_word == a[W-1:0], "R2", safe_word, a);
        tick();
        peer_word = a[W-1:0];
        tick();
      end
    end
    local_valid = 0; peer_valid = 0;
    chk(state_o == 3'd1, "R3 single mismatches", state_o, 1);

    // R3: matching compare breaks the streak
    cmp(1,1,0); cmp(1,1,0); cmp(1,1,1); cmp(1,1,0); cmp(1,1,0);
    chk(state_o == 3'd1, "R3 match clears", state_o, 1);
    cmp(1,1,1);
    // R3: idle and one-sided cycles hold the streak
    cmp(1,1,0); cmp(0,0,0); cmp(1,1,0); cmp(1,0,0); cmp(0,1,0);
    chk(state_o == 3'd1, "R3 hold", state_o, 1);
    cmp(1,1,0);
    chk(state_o == 3'd2, "R3 trip after gaps", state_o, 2);
    n = 0;
    tick();
    while (state_o == 3'd3 && n < 100) begin tick(); n++; end
    chk(state_o == 3'd1, "R6 retry", state_o, 1);   // budget count 1

    // R7: budget exhausted inside window
    trip_cycle("R6", fin);
    chk(fin == 1, "R6 retry second", fin, 1);
    trip_cycle("R7", fin);
    chk(fin == 4, "R7 lockout", fin, 4);
    repeat (20) tick();
    chk(state_o == 3'd4, "R9 stays locked", state_o, 4);
    ack_exit("R9");
    ack_btn = 0;
    chk(state_o == 3'd1, "R9 back to run", state_o, 1);

    // R9: ack outside LOCKOUT ignored
    repeat (3) tick();
    ack_btn = 1; repeat (10) tick();
    chk(state_o == 3'd1, "R9 ack in run", state_o, 1);
    ack_btn = 0; repeat (3) tick();

    // R7: window expiry reopens budget
    trip_cycle("R7", fin);
    chk(fin == 1, "R7 trip1", fin, 1);
    repeat (WIN + 20) tick();
    trip_cycle("R7", fin);
    chk(fin == 1, "R7 new window trip1", fin, 1);
    trip_cycle("R7", fin);
    chk(fin == 1, "R7 new window trip2", fin, 1);
    trip_cycle("R7", fin);
    chk(fin == 4, "R7 new window trip3", fin, 4);
    ack_exit("R9");
    ack_btn = 0;

    // R8 latched mode, R9 held button
    mode_latch = 1;
    repeat (3) tick();
    trip_cycle("R8", fin);
    chk(fin == 4, "R8 latch", fin, 4);
    ack_exit("R9");
    trip_cycle("R8", fin);
    chk(fin == 4, "R8 latch again", fin, 4);
    repeat (30) tick();
    chk(state_o == 3'd4, "R9 held ack ignored", state_o, 4);
    ack_btn = 0; repeat (5) tick();
    ack_exit("R9");
    ack_btn = 0; mode_latch = 0;
    repeat (3) tick();

    // R4 heartbeat loss
    hb_on = 0;
    n = 0;
    while (state_o == 3'd1 && n < 200) begin tick(); n++; end
    chk(state_o == 3'd2, "R4 trip", state_o, 2);
    chk(n >= HBT - 13 && n <= HBT + 4, "R4 distance", n, HBT);
    hb_on = 1;

    // R10 own keep-alive
    tg = 0; last = hb_out;
    repeat (100) begin
      tick();
      if (hb_out != last) tg++;
      last = hb_out;
    end
    chk(tg == 100 / HBH, "R10", tg, 100 / HBH);

    finish_run();
  end
endmodule